// File: doc/BRIEF.md
# Multi-Standard Serial Audio Receiver

This block turns a serial audio stream (bit clock, word select, serial data) into 16-bit parallel samples. Each sample carries a tag that says whether it belongs to the left or the right channel. A 2-bit code picks one of four framing standards. A second input says whether each channel occupies a 16-bit or a 32-bit slot. Only the 16 data bits inside the chosen window are captured, and the other bits of the slot are discarded.

The receiver works in either of two roles. As clock master it drives word select itself. As slave it follows an external word select. In both roles the bit clock comes in on `sck` and is sampled by the system clock, so `sck` must be generated in the `clk` domain.

The host side is a one-entry buffer. A not-empty flag is set when a sample is loaded and is cleared by a one-cycle read strobe. If a new sample arrives before the previous one was read, the buffer is overwritten and a sticky overrun flag is raised. A busy output stays high while the receiver is enabled or while a capture is still in progress. When the enable is dropped, the sample already being received still completes.

Top module: `i2s_audio_rx`

## Requirements
- R1: Framing code 00 is Philips framing: the MSB is captured on the second rising bit-clock edge after a word-select change. Code 01 is MSB-justified framing: the MSB is captured on the same rising edge where the word-select change is first seen. In both, the 16 bits arrive MSB first, one per rising edge.
- R2: Framing code 10 is LSB-justified framing: the 16 data bits fill the last 16 bit times of the slot. With a 32-bit slot, the MSB is captured 16 rising edges after the word-select change.
- R3: Framing code 11 is PCM framing: word select is high for exactly one bit time as a frame sync. The MSB is captured on the next rising edge, and every PCM sample is tagged as the left channel (side = 0).
- R4: `chan32` = 1 selects a 32-bit slot and `chan32` = 0 selects a 16-bit slot. Serial bits outside the 16-bit data window never change the captured sample.
- R5: When a sample completes, `rx_data` holds it, with the first received bit at bit 15, and `rx_nempty` goes high. A one-cycle `rd` strobe clears `rx_nempty`. After reset, `rx_nempty` is 0.
- R6: If a sample completes while `rx_nempty` is already high and no read occurs in that cycle, the new sample replaces the old one and `rx_overrun` goes high. The same `rd` strobe that clears `rx_nempty` also clears `rx_overrun`. The flag is never high while `rx_nempty` is low.
- R7: `rx_side` is the word-select level of the slot that carried the sample: 0 means left and 1 means right. In slave mode this level is taken from `ws_in`.
- R8: In master mode, `ws_out` is 0 after reset and while idle. It starts low when the receiver is enabled and toggles after every 16 or 32 rising bit-clock edges, as set by `chan32`.
- R9: `busy` is 0 after reset, and is high while `en` is high or a capture is in progress. When `en` falls in the middle of a sample, that sample still completes and is flagged. No new capture starts after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Receiver enable |
| master | input | 1 | 1 = drive word select, 0 = follow `ws_in` |
| std_sel | input | 2 | Framing standard: 00 Philips, 01 MSB-justified, 10 LSB-justified, 11 PCM |
| chan32 | input | 1 | Slot length: 1 = 32 bits, 0 = 16 bits |
| sck | input | 1 | Bit clock, sampled by `clk` |
| ws_in | input | 1 | External word select (slave mode) |
| sd | input | 1 | Serial data, captured on rising `sck` |
| rd | input | 1 | Host read strobe, one cycle |
| ws_out | output | 1 | Word select driven in master mode |
| rx_data | output | 16 | Received sample |
| rx_side | output | 1 | Channel tag: 0 left, 1 right |
| rx_nempty | output | 1 | Buffer holds an unread sample |
| rx_overrun | output | 1 | Sticky flag: an unread sample was overwritten |
| busy | output | 1 | Receiver enabled or a capture is still running |

## Verification
Every bit outside the data window is driven to 1, and each data word begins with 8001h followed by random words. A window shifted by one bit, a dropped edge bit or a leaked padding bit therefore shows up as a wrong sample rather than a plausible one. Each framing code is run with both slot lengths, and Philips and MSB-justified framing are also run in master mode. This separates the placements of the four standards from one another and from the side tag sequence. Two further patterns check the flag behaviour: one disables the receiver part-way through a 32-bit LSB-justified sample, and one lets two samples arrive with no read in between.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;

    localparam int SAMPLE_W = 16;

    typedef enum logic [1:0] {
        STD_PHILIPS = 2'b00,
        STD_MSB     = 2'b01,
        STD_LSB     = 2'b10,
        STD_PCM     = 2'b11
    } std_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] data;
        logic                side;
    } sample_t;

    // Rising-edge detector for the oversampled bit clock.
    function automatic logic rise(input logic now, input logic prev);
        return now & ~prev;
    endfunction

endpackage

// File: rtl/i2srx_frame.sv
module i2srx_frame
    import i2srx_pkg::*;
#(
    parameter int SLOT_S = 16,
    parameter int SLOT_L = 32,
    parameter int DATA_W = SAMPLE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic master,
    input  std_e std,
    input  logic chan32,
    input  logic sck,
    input  logic ws_in,
    input  logic active,
    output logic tick,
    output logic start,
    output logic start_side,
    output logic ws_out
);
    localparam int POS_W = $clog2(SLOT_L) + 1;
    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic             sck_q, ws_prev, synced, run, ws_now, ws_edge;
    logic [POS_W-1:0] pos, pos_cur, slot_len, lsb_pos, mcnt;

    assign run      = en | active;
    assign tick     = rise(sck, sck_q);
    assign ws_now   = master ? ws_out : ws_in;
    assign ws_edge  = ws_now ^ ws_prev;
    assign slot_len = chan32 ? POS_W'(SLOT_L) : POS_W'(SLOT_S);
    assign lsb_pos  = slot_len - POS_W'(DATA_W);

    // Position of the current bit inside its slot (0 = first bit after a change).
    always_comb begin
        if (ws_edge)             pos_cur = '0;
        else if (pos == POS_MAX) pos_cur = pos;
        else                     pos_cur = pos + POS_W'(1);
    end

    always_comb begin
        start = 1'b0;
        if (tick && en) begin
            unique case (std)
                STD_PHILIPS: start = synced && (pos_cur == POS_W'(1));
                STD_MSB:     start = ws_edge;
                STD_LSB:     start = (synced || ws_edge) && (pos_cur == lsb_pos);
                default:     start = ws_prev && !ws_now;
            endcase
        end
    end

    assign start_side = (std == STD_PCM) ? 1'b0 : ws_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            ws_prev <= 1'b0;
            synced  <= 1'b0;
            pos     <= '0;
            mcnt    <= '0;
            ws_out  <= 1'b0;
        end else begin
            sck_q <= sck;
            if (tick) ws_prev <= ws_now;
            if (!run) begin
                synced <= 1'b0;
                pos    <= '0;
                mcnt   <= '0;
                ws_out <= 1'b0;
            end else if (tick) begin
                pos <= pos_cur;
                if (ws_edge) synced <= 1'b1;
                if (master) begin
                    if (mcnt == slot_len - POS_W'(1)) begin
                        mcnt   <= '0;
                        ws_out <= (std == STD_PCM) ? 1'b1 : ~ws_out;
                    end else begin
                        mcnt <= mcnt + POS_W'(1);
                        if (std == STD_PCM) ws_out <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2srx_shift.sv
module i2srx_shift
    import i2srx_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    start,
    input  logic    start_side,
    input  logic    sd,
    output logic    active,
    output logic    done,
    output sample_t smp
);
    localparam int CNT_W = $clog2(DATA_W) + 1;

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;
    logic              side;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            sh     <= '0;
            side   <= 1'b0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (start) begin
                    sh     <= {sh[DATA_W-2:0], sd};
                    cnt    <= CNT_W'(1);
                    active <= 1'b1;
                    side   <= start_side;
                end else if (active) begin
                    sh  <= {sh[DATA_W-2:0], sd};
                    cnt <= cnt + CNT_W'(1);
                    if (cnt == CNT_W'(DATA_W - 1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end

    assign smp.data = sh;
    assign smp.side = side;
endmodule

// File: rtl/i2srx_buffer.sv
module i2srx_buffer
    import i2srx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    done,
    input  sample_t smp_in,
    input  logic    rd,
    output sample_t held,
    output logic    nempty,
    output logic    overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            nempty  <= 1'b0;
            overrun <= 1'b0;
        end else if (done) begin
            held    <= smp_in;
            nempty  <= 1'b1;
            overrun <= (overrun | nempty) & ~rd;
        end else if (rd) begin
            nempty  <= 1'b0;
            overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/i2s_audio_rx.sv
module i2s_audio_rx
    import i2srx_pkg::*;
#(
    parameter int SLOT_S = 16,
    parameter int SLOT_L = 32,
    parameter int DATA_W = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              master,
    input  logic [1:0]        std_sel,
    input  logic              chan32,
    input  logic              sck,
    input  logic              ws_in,
    input  logic              sd,
    input  logic              rd,
    output logic              ws_out,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_side,
    output logic              rx_nempty,
    output logic              rx_overrun,
    output logic              busy
);
    logic    tick, start, start_side, active, done;
    sample_t cap, held;
    std_e    std;

    assign std = std_e'(std_sel);

    i2srx_frame #(.SLOT_S(SLOT_S), .SLOT_L(SLOT_L), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst(rst), .en(en), .master(master), .std(std),
        .chan32(chan32), .sck(sck), .ws_in(ws_in), .active(active),
        .tick(tick), .start(start), .start_side(start_side), .ws_out(ws_out)
    );

    i2srx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .tick(tick), .start(start),
        .start_side(start_side), .sd(sd), .active(active),
        .done(done), .smp(cap)
    );

    i2srx_buffer u_buf (
        .clk(clk), .rst(rst), .done(done), .smp_in(cap), .rd(rd),
        .held(held), .nempty(rx_nempty), .overrun(rx_overrun)
    );

    assign rx_data = held.data;
    assign rx_side = held.side;
    assign busy    = en | active;
endmodule

// File: rtl/i2srx_checker.sv
module i2srx_checker (
    input logic       clk,
    input logic       rst,
    input logic       rd,
    input logic       start,
    input logic       active,
    input logic       done,
    input logic       rx_nempty,
    input logic       rx_overrun,
    input logic       rx_side,
    input logic       busy,
    input logic       ws_out,
    input logic [1:0] std_sel
);
    assert_window_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);

    assert_overrun_needs_full_R6: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |-> rx_nempty);

    assert_read_empties_R5: assert property (@(posedge clk) disable iff (rst)
        (rd && !done) |=> !rx_nempty);

    assert_capture_end_flagged_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |=> rx_nempty);

    assert_pcm_left_tag_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_nempty) && std_sel == 2'b11) |-> !rx_side);

    assert_idle_ws_low_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> !ws_out);
endmodule

bind i2s_audio_rx i2srx_checker u_chk (
    .clk(clk), .rst(rst), .rd(rd), .start(start), .active(active),
    .done(done), .rx_nempty(rx_nempty), .rx_overrun(rx_overrun),
    .rx_side(rx_side), .busy(busy), .ws_out(ws_out), .std_sel(std_sel)
);

// File: tb/tb_i2s_audio_rx.sv
module tb_i2s_audio_rx;
    import i2srx_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1, en = 1'b0, master = 1'b0, chan32 = 1'b0;
    logic        sck = 1'b0, ws_in = 1'b0, sd = 1'b0, rd = 1'b0;
    logic [1:0]  std_sel = 2'b00;
    logic        ws_out, rx_side, rx_nempty, rx_overrun, busy;
    logic [15:0] rx_data;

    i2s_audio_rx dut (
        .clk(clk), .rst(rst), .en(en), .master(master), .std_sel(std_sel),
        .chan32(chan32), .sck(sck), .ws_in(ws_in), .sd(sd), .rd(rd),
        .ws_out(ws_out), .rx_data(rx_data), .rx_side(rx_side),
        .rx_nempty(rx_nempty), .rx_overrun(rx_overrun), .busy(busy)
    );

    typedef struct { logic [15:0] d; logic s; } exp_t;

    int    total = 0, bad = 0;
    bit    finished = 0;
    string cur_req = "R1";
    bit    ws_arr [0:1023];
    bit    sd_arr [0:1023];
    int    T;
    logic [15:0] smp [0:7];
    exp_t  exp_q [$];
    bit    auto_read = 1;
    int    rd_req_n = 0, rd_done_n = 0;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] expv, input string what);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard whenever a sample is flagged.
    always @(negedge clk) begin : monitor
        exp_t e;
        if (rd) rd <= 1'b0;
        else if (auto_read && rx_nempty) begin
            if (exp_q.size() == 0) check(cur_req, 1, 0, "unexpected sample");
            else begin
                e = exp_q.pop_front();
                check(cur_req, rx_data, e.d, "data");
                check(cur_req, rx_side, e.s, "side");
            end
            rd <= 1'b1;
        end else if (rd_req_n != rd_done_n) begin
            rd_done_n++;
            rd <= 1'b1;
        end
    end

    // Driver side: lay out the serial stream and push the expected samples.
    task automatic build(input std_e st, input bit ch32, input bit mst,
                         input int n, input int nexp);
        int slot, p, s, off;
        slot = ch32 ? 32 : 16;
        for (int i = 0; i < 1024; i++) begin ws_arr[i] = 0; sd_arr[i] = 1; end
        for (int j = 0; j < n; j++) smp[j] = (j == 0) ? 16'h8001 : 16'($urandom);
        if (st == STD_PCM) begin
            p = 2;
            for (int j = 0; j < n; j++) begin
                s = p + j * (slot + 1);
                ws_arr[s] = 1;
                for (int b = 0; b < 16; b++) sd_arr[s+1+b] = smp[j][15-b];
            end
            T = p + n * (slot + 1);
        end else begin
            p = mst ? slot : 2;
            off = (st == STD_PHILIPS) ? 1 : (st == STD_LSB) ? slot - 16 : 0;
            for (int j = 0; j < n; j++) begin
                s = p + j * slot;
                for (int k = 0; k < slot; k++) ws_arr[s+k] = (j % 2 == 0);
                for (int b = 0; b < 16; b++) sd_arr[s+off+b] = smp[j][15-b];
            end
            T = p + n * slot;
            if (st == STD_PHILIPS) begin ws_arr[T] = (n % 2 == 0); T++; end
        end
        for (int j = 0; j < nexp; j++) begin
            exp_t e;
            e.d = smp[j];
            e.s = (st == STD_PCM) ? 1'b0 : (j % 2 == 0);
            exp_q.push_back(e);
        end
    endtask

    task automatic play(input bit mst, input int drop_at);
        for (int i = 0; i < T; i++) begin
            @(negedge clk);
            sck = 0; ws_in = mst ? 1'b0 : ws_arr[i]; sd = sd_arr[i];
            if (mst) check("R8", ws_out, ws_arr[i], "ws_out level");
            if (i == drop_at) begin
                en = 0;
                @(negedge clk);
                check("R9", busy, 1, "busy while last sample finishes");
                repeat (2) @(negedge clk);
            end else repeat (3) @(negedge clk);
            sck = 1;
            repeat (4) @(negedge clk);
        end
        @(negedge clk) sck = 0;
        repeat (20) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; en = 0; sck = 0; ws_in = 0; sd = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic run_case(input string req, input std_e st, input bit ch32,
                            input bit mst, input int n, input int nexp,
                            input int drop_at);
        do_reset();
        std_sel = st; chan32 = ch32; master = mst; cur_req = req;
        en = 1;
        @(negedge clk);
        check("R9", busy, 1, "busy when enabled");
        build(st, ch32, mst, n, nexp);
        play(mst, drop_at);
        en = 0;
        repeat (4) @(negedge clk);
        check(req, exp_q.size(), 0, "samples still pending");
        exp_q.delete();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        check("R5", rx_nempty, 0, "nempty after reset");
        check("R6", rx_overrun, 0, "overrun after reset");
        check("R9", busy, 0, "busy after reset");
        check("R8", ws_out, 0, "ws_out after reset");

        run_case("R1", STD_PHILIPS, 1, 0, 4, 4, -1);
        run_case("R1", STD_PHILIPS, 0, 0, 4, 4, -1);
        run_case("R1", STD_MSB,     0, 0, 4, 4, -1);
        run_case("R4", STD_MSB,     1, 0, 4, 4, -1);
        run_case("R2", STD_LSB,     1, 0, 4, 4, -1);
        run_case("R2", STD_LSB,     0, 0, 4, 4, -1);
        run_case("R3", STD_PCM,     1, 0, 3, 3, -1);
        run_case("R3", STD_PCM,     0, 0, 3, 3, -1);
        run_case("R7", STD_PHILIPS, 1, 1, 4, 4, -1);
        run_case("R8", STD_MSB,     0, 1, 4, 4, -1);

        // R9: drop enable inside the data window of the third 32-bit LSB slot.
        run_case("R9", STD_LSB, 1, 0, 4, 3, 2 + 2*32 + 20);
        check("R9", busy, 0, "busy after final sample");

        // R6: two samples with no read in between.
        auto_read = 0;
        do_reset();
        std_sel = STD_MSB; chan32 = 0; master = 0; cur_req = "R6";
        en = 1;
        build(STD_MSB, 0, 0, 2, 0);
        play(0, -1);
        check("R6", rx_overrun, 1, "overrun after unread sample");
        check("R6", rx_nempty, 1, "nempty with overrun");
        check("R6", rx_data, smp[1], "newest sample kept");
        check("R7", rx_side, 0, "side of left slot");
        rd_req_n++;
        repeat (4) @(negedge clk);
        check("R5", rx_nempty, 0, "nempty cleared by read");
        check("R6", rx_overrun, 0, "overrun cleared by read");
        auto_read = 1;
        en = 0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule